// File: doc/BRIEF.md
# Hybrid Conditional-Carry / Conditional-Sum Adder

This block adds two W-bit operands and an optional carry-in, and registers the W-bit sum and the carry-out on the next clock. Every bit is reduced to three terms: r (either operand set), g (both set) and p (exactly one set). Every carry is then a two-way selection: the incoming carry picks r when it is 1 and g when it is 0.

The bits below a parameterised boundary form a conditional-carry section. It resolves its carries first, adjacent bits merged in pairs, and XORs each carry with p as the last step. The bits from the boundary upward form one conditional-sum block. That block builds both possible sums in advance from ordered prefix groups of its (r, g) pairs, and the carry that arrives from below selects one of them together with the carry-out. The boundary may lie anywhere from 0 (the whole adder is conditional-sum) to W (the whole adder is conditional-carry). A second parameter removes the carry-in, and bit 0 then acts as a half adder.

The output stage has a synchronous, active-high reset, as used in FPGA pipelines.

Top module: `hccs_adder`

## Requirements
- R1: One clock after inputs are presented (reset low), `sum` equals the low W bits of a + b + carry-in, where the carry-in is `cin` when CIN_EN = 1 and 0 otherwise.
- R2: While `rst` is high at a rising clock edge, `sum` and `cout` are 0 after that edge.
- R3: `cout` equals bit W of the (W+1)-bit total a + b + carry-in, registered with the same latency as `sum`.
- R4: The bits below CS_START produce the correct sum and section carry-out for every operand pair and every section carry-in, with carries formed as c(n+1) = c(n) ? r(n) : g(n) and pair-merged groups.
- R5: The block from CS_START to W-1 precomputes a candidate sum for block carry-in 0 and one for block carry-in 1, and the arriving carry selects the correct candidate and block carry-out in both cases.
- R6: With CIN_EN = 0, `cin` has no effect on `sum` or `cout`, and bit 0 behaves as a half adder.
- R7: Results are correct for any CS_START from 0 to W, including the all-conditional-sum (0) and all-conditional-carry (W) forms.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the output registers |
| a | input | W | First operand |
| b | input | W | Second operand |
| cin | input | 1 | Carry-in, used only when CIN_EN = 1 |
| sum | output | W | Registered sum |
| cout | output | 1 | Registered carry-out |

## Verification
At eight bits, all 65,536 operand pairs are applied, with the carry-in derived from the operand bits. This drives carries that ripple the whole width, that stop at the boundary, and that start inside the upper block. Three boundary settings (4, 0 and 8) receive the same stimulus, so a wrong mux order or a wrong candidate choice in either structure shows as a wrong total. A 32-bit copy without carry-in gets random pairs plus all-ones and zero corners while `cin` toggles; this shows that the carry-in is ignored and that long carry chains cross a boundary at bit 20. Reset is asserted both at start-up and in mid-stream to check that the outputs clear.

// File: rtl/hccs_pkg.sv
package hccs_pkg;

  // carry-select pair: r = carry-out when carry-in is 1, g = when 0
  typedef struct packed {
    logic r;
    logic g;
  } rg_t;

  // lower group first, upper group second; order may not be swapped
  function automatic rg_t rg_merge(input rg_t lo, input rg_t hi);
    rg_t m;
    m.r = lo.r ? hi.r : hi.g;
    m.g = lo.g ? hi.r : hi.g;
    return m;
  endfunction

endpackage

// File: rtl/hccs_bit_terms.sv
module hccs_bit_terms #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] r,
  output logic [W-1:0] g,
  output logic [W-1:0] p
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign r[i] = a[i] | b[i];
    assign g[i] = a[i] & b[i];
    assign p[i] = a[i] ^ b[i];
  end
endmodule

// File: rtl/hccs_cc_section.sv
module hccs_cc_section
  import hccs_pkg::*;
#(
  parameter int N = 4
) (
  input  logic [N-1:0] r,
  input  logic [N-1:0] g,
  input  logic [N-1:0] p,
  input  logic         cin,
  output logic [N-1:0] s,
  output logic         cout
);
  logic [N:0] c;
  assign c[0] = cin;

  for (genvar n = 0; n < N; n++) begin : g_car
    if ((n % 2) == 1) begin : g_pair
      // carry two bits up from the even carry using a merged pair
      rg_t pr;
      assign pr     = rg_merge('{r: r[n-1], g: g[n-1]}, '{r: r[n], g: g[n]});
      assign c[n+1] = c[n-1] ? pr.r : pr.g;
    end else begin : g_single
      assign c[n+1] = c[n] ? r[n] : g[n];
    end
  end

  // sums last: resolved carry XOR propagate
  assign s    = p ^ c[N-1:0];
  assign cout = c[N];

  // a_r4_cc_arith: section result matches arithmetic on the bit terms
  always_comb begin
    if (!$isunknown({r, g, p, cin})) begin
      a_r4_cc_arith: assert ({cout, s} ==
        ({1'b0, p} + {g, 1'b0} + {{N{1'b0}}, cin}))
        else $error("R4 conditional-carry section result wrong");
    end
  end
endmodule

// File: rtl/hccs_cs_block.sv
module hccs_cs_block
  import hccs_pkg::*;
#(
  parameter int N = 4
) (
  input  logic [N-1:0] r,
  input  logic [N-1:0] g,
  input  logic [N-1:0] p,
  input  logic         cin,
  output logic [N-1:0] s,
  output logic         cout
);
  rg_t        pre [N];
  logic [N-1:0] cand0, cand1;

  assign pre[0] = '{r: r[0], g: g[0]};
  for (genvar k = 1; k < N; k++) begin : g_pre
    assign pre[k] = rg_merge(pre[k-1], '{r: r[k], g: g[k]});
  end

  // both candidate sums are ready before the block carry arrives
  assign cand0[0] = p[0];
  assign cand1[0] = ~p[0];
  for (genvar k = 1; k < N; k++) begin : g_cand
    assign cand0[k] = p[k] ^ pre[k-1].g;
    assign cand1[k] = p[k] ^ pre[k-1].r;
  end

  assign s    = cin ? cand1 : cand0;
  assign cout = cin ? pre[N-1].r : pre[N-1].g;

  always_comb begin
    if (!$isunknown({r, g, p, cin})) begin
      // a_r5_cs_arith: selected candidate and carry match arithmetic
      a_r5_cs_arith: assert ({cout, s} ==
        ({1'b0, p} + {g, 1'b0} + {{N{1'b0}}, cin}))
        else $error("R5 conditional-sum block result wrong");
      // a_r5_cs_order: carry with block carry-in 0 implies carry with 1
      a_r5_cs_order: assert (!pre[N-1].g || pre[N-1].r)
        else $error("R5 group terms out of order");
    end
  end
endmodule

// File: rtl/hccs_adder.sv
module hccs_adder #(
  parameter int W        = 8,
  parameter int CS_START = 4,
  parameter bit CIN_EN   = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  localparam int CC_W = CS_START;
  localparam int CS_W = W - CS_START;

  logic [W-1:0] r, g, p;
  logic [W-1:0] sum_d;
  logic         c0, c_mid, cout_d;

  // without a carry-in bit 0 reduces to a half adder
  assign c0 = CIN_EN ? cin : 1'b0;

  hccs_bit_terms #(.W(W)) u_terms (.a(a), .b(b), .r(r), .g(g), .p(p));

  if (CC_W > 0) begin : g_cc
    hccs_cc_section #(.N(CC_W)) u_cc (
      .r(r[CC_W-1:0]), .g(g[CC_W-1:0]), .p(p[CC_W-1:0]),
      .cin(c0), .s(sum_d[CC_W-1:0]), .cout(c_mid));
  end else begin : g_no_cc
    assign c_mid = c0;
  end

  if (CS_W > 0) begin : g_cs
    hccs_cs_block #(.N(CS_W)) u_cs (
      .r(r[W-1:CC_W]), .g(g[W-1:CC_W]), .p(p[W-1:CC_W]),
      .cin(c_mid), .s(sum_d[W-1:CC_W]), .cout(cout_d));
  end else begin : g_no_cs
    assign cout_d = c_mid;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum  <= '0;
      cout <= 1'b0;
    end else begin
      sum  <= sum_d;
      cout <= cout_d;
    end
  end

  // arithmetic reference for the checks only
  logic [W:0] total_ref;
  assign total_ref = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, c0};

  // a_r1_registered_sum / a_r3_carry_out
  a_r1_registered_sum: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> sum == $past(total_ref[W-1:0]))
    else $error("R1 sum mismatch");
  a_r3_carry_out: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> cout == $past(total_ref[W]))
    else $error("R3 carry-out mismatch");
  // a_r2_reset_clears
  a_r2_reset_clears: assert property (@(posedge clk)
    rst |=> (sum == '0 && cout == 1'b0))
    else $error("R2 outputs not cleared");
  // a_r6_cin_ignored: with no carry-in, total never exceeds a + b
  a_r6_cin_ignored: assert property (@(posedge clk) disable iff (rst)
    (!CIN_EN && !$past(rst)) |->
      {cout, sum} == ($past({1'b0, a}) + $past({1'b0, b})))
    else $error("R6 carry-in leaked");
endmodule

// File: tb/hccs_adder_bench.sv
module hccs_adder_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;   // 50 MHz

  logic [7:0]  a8 = '0, b8 = '0;
  logic [31:0] a32 = '0, b32 = '0;
  logic        cin = 1'b0;

  logic [7:0]  s_def, s_cs0, s_cs8;
  logic [31:0] s_w32;
  logic        co_def, co_cs0, co_cs8, co_w32;

  hccs_adder #(.W(8), .CS_START(4), .CIN_EN(1'b1)) u_hccs_adder (
    .clk(clk), .rst(rst), .a(a8), .b(b8), .cin(cin), .sum(s_def), .cout(co_def));
  hccs_adder #(.W(8), .CS_START(0), .CIN_EN(1'b1)) u_w8_cs0 (
    .clk(clk), .rst(rst), .a(a8), .b(b8), .cin(cin), .sum(s_cs0), .cout(co_cs0));
  hccs_adder #(.W(8), .CS_START(8), .CIN_EN(1'b1)) u_w8_cs8 (
    .clk(clk), .rst(rst), .a(a8), .b(b8), .cin(cin), .sum(s_cs8), .cout(co_cs8));
  hccs_adder #(.W(32), .CS_START(20), .CIN_EN(1'b0)) u_w32 (
    .clk(clk), .rst(rst), .a(a32), .b(b32), .cin(cin), .sum(s_w32), .cout(co_w32));

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [8:0]  q8[$];
  logic [32:0] q32[$];

  task automatic chk(input string tag, input logic [32:0] got, input logic [32:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h expected=%h", tag, got, exp);
    end
  endtask

  // at a falling edge: compare the previous results, then drive new inputs
  task automatic step(input logic [7:0] na, input logic [7:0] nb, input logic nc,
                      input logic [31:0] wa, input logic [31:0] wb);
    @(negedge clk);
    if (q8.size() > 0) begin
      logic [8:0]  e8;
      logic [32:0] e32;
      e8  = q8.pop_front();
      e32 = q32.pop_front();
      chk("R1 R4 R5 sum CS_START=4", {25'd0, s_def}, {25'd0, e8[7:0]});
      chk("R3 carry-out CS_START=4", {32'd0, co_def}, {32'd0, e8[8]});
      chk("R7 CS_START=0 total", {24'd0, co_cs0, s_cs0}, {24'd0, e8});
      chk("R7 R4 CS_START=8 total", {24'd0, co_cs8, s_cs8}, {24'd0, e8});
      chk("R6 W=32 no carry-in total", {co_w32, s_w32}, e32);
    end
    a8 = na; b8 = nb; cin = nc; a32 = wa; b32 = wb;
    q8.push_back({1'b0, na} + {1'b0, nb} + {8'd0, nc});
    q32.push_back({1'b0, wa} + {1'b0, wb});   // cin ignored
  endtask

  task automatic reset_check();
    @(negedge clk);
    rst = 1'b1;
    a8 = 8'hff; b8 = 8'hff; cin = 1'b1; a32 = '1; b32 = '1;
    q8.delete(); q32.delete();
    @(negedge clk);
    chk("R2 reset clears CS_START=4", {24'd0, co_def, s_def}, 33'd0);
    chk("R2 reset clears W=32", {co_w32, s_w32}, 33'd0);
    rst = 1'b0;
  endtask

  initial begin
    #(20 * 190000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    reset_check();
    // R5 both block carry-in values, R1 carry chains: corner pairs
    step(8'hff, 8'h01, 1'b0, 32'hffff_ffff, 32'h1);
    step(8'h0f, 8'h00, 1'b1, 32'h000f_ffff, 32'h1);   // carry reaches bit 20
    step(8'h0f, 8'h00, 1'b0, 32'h0, 32'h0);
    step(8'hff, 8'hff, 1'b1, 32'hffff_ffff, 32'hffff_ffff);
    // exhaustive at W=8, carry-in mixed from operand bits
    for (int i = 0; i < 65536; i++) begin
      logic [15:0] v;
      v = i[15:0];
      step(v[7:0], v[15:8], v[0] ^ v[9] ^ v[15],
           $urandom(), (i % 7 == 0) ? ~32'd0 : $urandom());
      if (i == 30000) reset_check();   // R2 mid-stream
    end
    step(8'h00, 8'h00, 1'b0, 32'h0, 32'h0);
    step(8'h00, 8'h00, 1'b0, 32'h0, 32'h0);  // flush last expectation
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule